// File: doc/BRIEF.md
# FSK Transponder Reader Baseband

This block is the digital baseband of a low-frequency RFID reader, running on a master clock of about 17.18 MHz. A single mode input selects one of two modes. In sending mode the block divides the master clock into a carrier and drives it on a pair of transmit pins. These pins feed an external complementary switch stage that drives the antenna.

In receiving mode the transmit pins are parked. The block then demodulates a squared frequency-shift-keyed signal from the analog front end. It synchronizes the input and finds each rising edge. It counts master clocks over each full input period and compares the count with a fixed threshold to recover one data bit per period. The bit appears on an active-low data output. A data clock, derived from the received edges, runs in both modes.

Top module: `fsk_reader_core`

## Requirements
- R1: While `rst` is high and on the first cycle after it is released, `rx_data_n` is 1 and `rx_dclk` is 0. With `mode_send` at 0 at that point, `tx_hi` is 1 and `tx_lo_oe` is 0.
- R2: With `mode_send` = 1 (sending), `tx_hi` and `tx_lo` both carry the carrier and `tx_lo_oe` is 1. After the n-th clock edge in sending mode the carrier is 1 exactly when (n mod 128) >= 64. This gives the master clock divided by 128.
- R3: With `mode_send` = 0 (receiving), `tx_hi` is 1, `tx_lo_oe` is 0 (low side released) and `tx_lo` is 0. The carrier divider is held cleared.
- R4: In sending mode `rx_data_n` is 1 at all times, whatever arrives on `rx_fsk`.
- R5: `rx_dclk` equals bit 3 of the number of detected `rx_fsk` rising edges since reset, so it runs at the input rate divided by 16. It keeps counting in both modes.
- R6: A period is the number of master clock cycles between two successive detected rising edges. In receiving mode, a period above 132 sets `rx_data_n` to 0 (bit 1), and a period below 132 sets it to 1 (bit 0). The new value shows two clock edges after the edge that first samples `rx_fsk` high.
- R7: A period of exactly 132 counts as bit 0 (`rx_data_n` = 1), and a period of 133 counts as bit 1.
- R8: The period count saturates instead of wrapping. A period of 300 cycles still decides bit 1.
- R9: The first rising edge after reset only starts a measurement and leaves `rx_data_n` unchanged.
- R10: `rx_data_n` changes only on a detected rising edge and holds for the rest of the period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_send | input | 1 | 1 = sending, 0 = receiving |
| rx_fsk | input | 1 | Squared FSK input, asynchronous |
| tx_hi | output | 1 | High-side transmit drive |
| tx_lo | output | 1 | Low-side transmit drive |
| tx_lo_oe | output | 1 | Low-side drive enable, 0 = high impedance |
| rx_data_n | output | 1 | Demodulated data, active low (0 = bit 1) |
| rx_dclk | output | 1 | Data clock, input edges divided by 16 |

## Verification
The bench builds the block with its default parameters: divide ratio 128, threshold 132, count limit 255 and data clock ratio 16. The fixed threshold is part of the required behaviour, so these are the only values that matter. With these values, a full 300-cycle carrier sweep checks every divider phase twice. Every input period from 120 to 145 cycles is checked, which brackets the threshold on both sides. A 300-cycle period pushes the count past its limit, and a mode change in the middle of a pulse train shows the data clock running on while the data pin is pinned.

// File: rtl/fsk_rdr_pkg.sv
package fsk_rdr_pkg;

    typedef enum logic {
        MODE_RECV = 1'b0,
        MODE_SEND = 1'b1
    } mode_e;

    typedef struct packed {
        logic hi;
        logic lo;
        logic lo_oe;
    } tx_pins_t;

    // Period decision: strictly longer than the threshold means a one bit
    function automatic logic period_is_one(input int period, input int thresh);
        return (period > thresh);
    endfunction

    // Transmit pin pattern for a mode and carrier phase
    function automatic tx_pins_t tx_drive(input mode_e m, input logic carrier);
        tx_pins_t p;
        if (m == MODE_SEND) begin
            p.hi    = carrier;
            p.lo    = carrier;
            p.lo_oe = 1'b1;
        end else begin
            p.hi    = 1'b1;
            p.lo    = 1'b0;
            p.lo_oe = 1'b0;
        end
        return p;
    endfunction

endpackage

// File: rtl/fsk_rdr_sync.sv
module fsk_rdr_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_in,
    output logic rise
);
    logic [STAGES:0] chain_q;

    always_ff @(posedge clk) begin
        if (rst) chain_q[0] <= 1'b0;
        else     chain_q[0] <= async_in;
    end

    for (genvar i = 1; i <= STAGES; i++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) chain_q[i] <= 1'b0;
            else     chain_q[i] <= chain_q[i-1];
        end
    end

    assign rise = chain_q[STAGES-1] & ~chain_q[STAGES];
endmodule

// File: rtl/fsk_rdr_carrier.sv
module fsk_rdr_carrier #(
    parameter int DIV = 128
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic carrier
);
    localparam int W = $clog2(DIV);

    logic [W-1:0] div_q;

    always_ff @(posedge clk) begin
        if (rst || !run) div_q <= '0;
        else             div_q <= div_q + 1'b1;
    end

    assign carrier = div_q[W-1];
endmodule

// File: rtl/fsk_rdr_demod.sv
module fsk_rdr_demod
    import fsk_rdr_pkg::*;
#(
    parameter int THRESH  = 132,
    parameter int CNT_MAX = 255
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         rise,
    input  logic                         enable,
    output logic                         data_n,
    output logic [$clog2(CNT_MAX+1)-1:0] count
);
    localparam int             CW  = $clog2(CNT_MAX + 1);
    localparam logic [CW-1:0]  SAT = CW'(CNT_MAX);

    logic [CW-1:0] cnt_q;
    logic          armed_q;
    logic          data_n_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q    <= '0;
            armed_q  <= 1'b0;
            data_n_q <= 1'b1;
        end else if (rise) begin
            cnt_q   <= '0;
            armed_q <= 1'b1;
            if (armed_q && enable)
                data_n_q <= ~period_is_one(int'(cnt_q) + 1, THRESH);
        end else if (cnt_q != SAT) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign data_n = data_n_q;
    assign count  = cnt_q;
endmodule

// File: rtl/fsk_rdr_dclk.sv
module fsk_rdr_dclk #(
    parameter int RATIO = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic rise,
    output logic dclk
);
    localparam int W = $clog2(RATIO);

    logic [W-1:0] edge_q;

    always_ff @(posedge clk) begin
        if (rst)       edge_q <= '0;
        else if (rise) edge_q <= edge_q + 1'b1;
    end

    assign dclk = edge_q[W-1];
endmodule

// File: rtl/fsk_reader_core.sv
module fsk_reader_core
    import fsk_rdr_pkg::*;
#(
    parameter int DIV       = 128,
    parameter int THRESH    = 132,
    parameter int CNT_MAX   = 255,
    parameter int DCLK_DIV  = 16,
    parameter int SYNC_LEN  = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic mode_send,
    input  logic rx_fsk,
    output logic tx_hi,
    output logic tx_lo,
    output logic tx_lo_oe,
    output logic rx_data_n,
    output logic rx_dclk
);
    localparam int CW = $clog2(CNT_MAX + 1);

    mode_e         mode;
    logic          rise_w;
    logic          carrier_w;
    logic          demod_data_n;
    logic [CW-1:0] cnt_w;
    tx_pins_t      pins;

    assign mode = mode_e'(mode_send);

    fsk_rdr_sync #(.STAGES(SYNC_LEN)) u_sync (
        .clk(clk), .rst(rst), .async_in(rx_fsk), .rise(rise_w)
    );

    fsk_rdr_carrier #(.DIV(DIV)) u_carrier (
        .clk(clk), .rst(rst), .run(mode == MODE_SEND), .carrier(carrier_w)
    );

    fsk_rdr_demod #(.THRESH(THRESH), .CNT_MAX(CNT_MAX)) u_demod (
        .clk(clk), .rst(rst), .rise(rise_w), .enable(mode == MODE_RECV),
        .data_n(demod_data_n), .count(cnt_w)
    );

    fsk_rdr_dclk #(.RATIO(DCLK_DIV)) u_dclk (
        .clk(clk), .rst(rst), .rise(rise_w), .dclk(rx_dclk)
    );

    assign pins      = tx_drive(mode, carrier_w);
    assign tx_hi     = pins.hi;
    assign tx_lo     = pins.lo;
    assign tx_lo_oe  = pins.lo_oe;
    assign rx_data_n = (mode == MODE_SEND) ? 1'b1 : demod_data_n;
endmodule

// File: rtl/fsk_reader_core_chk.sv
module fsk_reader_core_chk #(
    parameter int CW      = 8,
    parameter int CNT_MAX = 255
) (
    input logic          clk,
    input logic          rst,
    input logic          mode_send,
    input logic          tx_hi,
    input logic          tx_lo,
    input logic          tx_lo_oe,
    input logic          rx_data_n,
    input logic          rx_dclk,
    input logic          rise,
    input logic          data_q,
    input logic [CW-1:0] cnt
);
    localparam logic [CW-1:0] SAT = CW'(CNT_MAX);

    // R3
    recv_park_chk: assert property (@(posedge clk) disable iff (rst)
        !mode_send |-> (tx_hi && !tx_lo && !tx_lo_oe));

    // R2
    send_pair_chk: assert property (@(posedge clk) disable iff (rst)
        mode_send |-> (tx_lo_oe && (tx_hi == tx_lo)));

    // R4
    send_data_high_chk: assert property (@(posedge clk) disable iff (rst)
        mode_send |-> rx_data_n);

    // R10
    data_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(data_q) |-> $past(rise));

    // R5
    dclk_step_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(rx_dclk) |-> $past(rise));

    // R8
    count_sat_chk: assert property (@(posedge clk) disable iff (rst)
        (cnt == SAT && !rise) |=> (cnt == SAT));
endmodule

bind fsk_reader_core fsk_reader_core_chk #(.CW(CW), .CNT_MAX(CNT_MAX)) u_chk (
    .clk(clk), .rst(rst), .mode_send(mode_send), .tx_hi(tx_hi), .tx_lo(tx_lo),
    .tx_lo_oe(tx_lo_oe), .rx_data_n(rx_data_n), .rx_dclk(rx_dclk),
    .rise(rise_w), .data_q(demod_data_n), .cnt(cnt_w)
);

// File: tb/tb_fsk_reader_core.sv
module tb_fsk_reader_core;
    localparam int THR = 132;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic mode_send = 1'b0;
    logic rx_fsk = 1'b0;
    logic tx_hi, tx_lo, tx_lo_oe, rx_data_n, rx_dclk;

    int checks = 0;
    int errors = 0;
    int edges  = 0;
    int last_p = 0;
    bit armed  = 1'b0;
    bit exp_dn = 1'b1;

    always #2 clk = ~clk;

    fsk_reader_core dut (
        .clk(clk), .rst(rst), .mode_send(mode_send), .rx_fsk(rx_fsk),
        .tx_hi(tx_hi), .tx_lo(tx_lo), .tx_lo_oe(tx_lo_oe),
        .rx_data_n(rx_data_n), .rx_dclk(rx_dclk)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        rx_fsk = 1'b0;
        mode_send = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 data during reset", rx_data_n, 1);
        rst = 1'b0;
        edges = 0; armed = 1'b0; exp_dn = 1'b1; last_p = 0;
        @(negedge clk);
        check("R1 data after reset", rx_data_n, 1);
        check("R1 dclk after reset", rx_dclk, 0);
        check("R1 tx_hi after reset", tx_hi, 1);
        check("R1 oe after reset", tx_lo_oe, 0);
    endtask

    // One input period of p cycles; checks the decision for the period just ended
    task automatic one_period(input int p);
        rx_fsk = 1'b1;
        repeat (3) @(negedge clk);
        edges++;
        if (mode_send) begin
            check("R4 data high in send", rx_data_n, 1);
        end else if (armed) begin
            exp_dn = (last_p > THR) ? 1'b0 : 1'b1;
            check($sformatf("R6 R7 R8 decision period=%0d", last_p), rx_data_n, exp_dn);
        end else begin
            check("R9 first edge no update", rx_data_n, exp_dn);
        end
        check("R5 dclk", rx_dclk, (edges >> 3) & 1);
        armed = 1'b1;
        repeat (p/2 - 3) @(negedge clk);
        if (!mode_send) check("R10 data holds", rx_data_n, exp_dn);
        rx_fsk = 1'b0;
        repeat (p - p/2) @(negedge clk);
        last_p = p;
    endtask

    initial begin
        #(4 * 200000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        do_reset();

        // Carrier sweep, R2, then parking, R3
        mode_send = 1'b1;
        for (int n = 1; n <= 300; n++) begin
            @(negedge clk);
            check("R2 carrier", tx_hi, ((n % 128) >= 64) ? 1 : 0);
            check("R2 low side", tx_lo, ((n % 128) >= 64) ? 1 : 0);
            check("R2 oe", tx_lo_oe, 1);
        end
        mode_send = 1'b0;
        #1;
        check("R3 tx_hi parked", tx_hi, 1);
        check("R3 tx_lo parked", tx_lo, 0);
        check("R3 oe released", tx_lo_oe, 0);
        @(negedge clk);
        mode_send = 1'b1;
        @(negedge clk);
        check("R3 divider cleared in receive", tx_hi, 0);
        mode_send = 1'b0;

        // Demodulation
        do_reset();
        repeat (200) @(negedge clk);
        one_period(140);
        for (int p = 120; p <= 145; p++) one_period(p);
        one_period(300);
        one_period(20);
        one_period(20);
        one_period(132);
        one_period(133);
        one_period(10);
        one_period(12);

        // Sending mode: data pinned, data clock running
        mode_send = 1'b1;
        for (int k = 0; k < 10; k++) one_period(140);
        mode_send = 1'b0;
        one_period(40);
        one_period(40);
        one_period(40);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule